// File: doc/BRIEF.md
# Cascadable LCD Column Data Driver

This block is the digital core of a 240-column liquid-crystal column driver. Pixel data arrives as 8-bit bytes, one byte on each falling edge of an external shift clock. A device accepts bytes only while its chain-enable input is low. It counts the bytes itself, and after 30 bytes it drives its chain-enable output low. That output starts the next device in a cascade, so several devices share one data bus and one shift clock with no outside select logic. The first device in a chain has its enable input tied low.

A falling edge on the line-latch input copies the captured row into an output latch. The latch pulse also re-arms the enable chain. Each column then drives a 2-bit level code. The code is chosen from the latched pixel, a frame-polarity input and an active-low blanking input. A direction input mirrors the column order and swaps which chain pin is the input and which is the output.

All logic runs on one fast system clock. The shift clock, latch pulse, data bus and control inputs pass through a synchronizer, and their edges are detected in the system clock domain. The shift-clock interface has no back-pressure: every falling edge is either taken or ignored. A valid/ready handshake therefore does not apply.

Top module: `lcd_col_drv`

## Requirements
- R1: On each falling shift-clock edge, while the selected chain input is low and fewer than 30 bytes have been taken since the last latch pulse, the device captures one byte. 30 bytes fill all 240 columns. While the chain input is high, shift-clock edges capture nothing.
- R2: The chain output is 1 after reset and after each falling edge of the latch pulse. It goes to 0 once the 30th byte of the row has been captured.
- R3: Shift-clock edges after the 30th byte of a row are ignored and leave the captured row unchanged.
- R4: With `dir_i` = 0, bit b of byte k (k = 0 first, b = 0 LSB) goes to column index 232 − 8k + b (0-based, index 0 = column 1). So bit 7 of the first byte lands on the last column. Pin B is the chain input and pin A is the chain output (`chain_a_oe` = 1, `chain_b_oe` = 0). The unused output pin reads 1.
- R5: With `dir_i` = 1, bit b of byte k goes to column index 8k + 7 − b. So bit 7 of the first byte lands on column index 0. Pin A is the chain input and pin B is the chain output (`chain_b_oe` = 1, `chain_a_oe` = 0).
- R6: Only a falling edge of `line_i` changes the output latch. Bytes captured between latch pulses do not appear at `level_o` until the next pulse.
- R7: With `show_i` = 1, the level code of each column is:
  - pixel 1 and frame 1 give 2'b00;
  - pixel 0 and frame 1 give 2'b01;
  - pixel 0 and frame 0 give 2'b10;
  - pixel 1 and frame 0 give 2'b11.
- R8: With `show_i` = 0, every column drives 2'b11, whatever the pixel and frame inputs are.
- R9: The active-low asynchronous reset clears the byte count, sets the chain output to 1 and clears the latch. `level_o` resets to all 2'b11. Once the inputs have settled, it shows the code for pixel 0 under the current frame and show inputs.
- R10: Every input passes through a two-flop synchronizer. Column column c is `level_o[2c+1:2c]`, and it is a register updated one system clock after the synchronized inputs and the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Column order and chain pin roles (quasi-static) |
| shclk_i | input | 1 | Shift clock; bytes are taken on its falling edge |
| pix_i | input | 8 | Pixel byte |
| line_i | input | 1 | Line latch pulse; acts on its falling edge |
| frame_i | input | 1 | Frame polarity |
| show_i | input | 1 | 0 forces all columns to 2'b11 |
| chain_a_i | input | 1 | Chain pin A, input value |
| chain_a_o | output | 1 | Chain pin A, output value |
| chain_a_oe | output | 1 | Chain pin A drives when 1 |
| chain_b_i | input | 1 | Chain pin B, input value |
| chain_b_o | output | 1 | Chain pin B, output value |
| chain_b_oe | output | 1 | Chain pin B drives when 1 |
| level_o | output | 480 | Two bits per column, column c at [2c+1:2c] |

## Verification
The bench chains two devices in each direction. It sends 60 bytes followed by surplus bytes.

- If the count is off by one, the handoff comes too early or too late, and the second device's row is shifted by one byte.
- If surplus bytes are not blocked, the tail of the row is overwritten with all-ones.
- If the mirrored mapping or the pin swap is wrong, the outputs reverse or the second device never starts.
- If the latch leaks, the outputs follow a row loaded without a latch pulse.
- If blanking is missing, the columns keep their data codes while `show_i` is low.

A per-clock model also catches any extra or missing register stage.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;

  typedef enum logic [1:0] {
    LVL_TOP    = 2'b00,
    LVL_HI_MID = 2'b01,
    LVL_LO_MID = 2'b10,
    LVL_BOTTOM = 2'b11
  } drive_lvl_e;

  function automatic drive_lvl_e pick_level(input logic pix, input logic frame,
                                            input logic show);
    drive_lvl_e r;
    if (!show) r = LVL_BOTTOM;
    else begin
      case ({pix, frame})
        2'b11:   r = LVL_TOP;
        2'b10:   r = LVL_BOTTOM;
        2'b01:   r = LVL_HI_MID;
        default: r = LVL_LO_MID;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/lcd_in_sync.sv
module lcd_in_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/lcd_chain_ctrl.sv
module lcd_chain_ctrl #(
  parameter int NUM_SLOTS = 30,
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1),
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_fall,
  input  logic              line_fall,
  input  logic              sel_n,
  output logic              wr_stb,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              done_n
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_SLOTS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_SLOTS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wr_stb  = shift_fall && !line_fall && !sel_n && (cnt_q < FULL);
  assign wr_slot = cnt_q[SLOT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_n <= 1'b1;
    end else if (line_fall) begin
      cnt_q  <= '0;
      done_n <= 1'b1;
    end else if (wr_stb) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) done_n <= 1'b0;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  p_done_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_fall |=> done_n);
  p_done_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_n) |-> cnt_q == FULL);
endmodule

// File: rtl/lcd_row_reg.sv
module lcd_row_reg #(
  parameter int BUS_W     = 8,
  parameter int NUM_SLOTS = 30,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int COLS   = BUS_W * NUM_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir,
  input  logic              wr_stb,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [BUS_W-1:0]  bus,
  output logic [COLS-1:0]   row
);
  logic [BUS_W-1:0] gated, flipped;
  logic [BUS_W-1:0] slot_q [NUM_SLOTS];

  // idle bus stays low so the slot inputs do not toggle
  assign gated = wr_stb ? bus : '0;

  always_comb begin
    for (int b = 0; b < BUS_W; b++) flipped[b] = gated[BUS_W-1-b];
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [SLOT_W-1:0] FWD = SLOT_W'(g);
    localparam logic [SLOT_W-1:0] REV = SLOT_W'(NUM_SLOTS - 1 - g);
    logic hit;
    assign hit = wr_stb && (dir ? (wr_slot == FWD) : (wr_slot == REV));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (hit) slot_q[g] <= dir ? flipped : gated;
    end
    assign row[g*BUS_W +: BUS_W] = slot_q[g];
  end

  p_no_write_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(row));
endmodule

// File: rtl/lcd_out_stage.sv
module lcd_out_stage
  import lcd_col_pkg::*;
#(
  parameter int COLS = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_fall,
  input  logic [COLS-1:0]   row,
  input  logic              frame,
  input  logic              show,
  output logic [2*COLS-1:0] level_o
);
  logic [COLS-1:0] latch_q;
  drive_lvl_e      lvl_q [COLS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latch_q <= '0;
    else if (line_fall) latch_q <= row;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[c] <= LVL_BOTTOM;
      else        lvl_q[c] <= pick_level(latch_q[c], frame, show);
    end
    assign level_o[2*c +: 2] = lvl_q[c];
  end

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_fall |=> $stable(latch_q));
  p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !show |=> (&level_o));
endmodule

// File: rtl/lcd_col_drv.sv
module lcd_col_drv #(
  parameter int BUS_W       = 8,
  parameter int NUM_COLS    = 240,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_SLOTS = NUM_COLS / BUS_W,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dir_i,
  input  logic                  shclk_i,
  input  logic [BUS_W-1:0]      pix_i,
  input  logic                  line_i,
  input  logic                  frame_i,
  input  logic                  show_i,
  input  logic                  chain_a_i,
  output logic                  chain_a_o,
  output logic                  chain_a_oe,
  input  logic                  chain_b_i,
  output logic                  chain_b_o,
  output logic                  chain_b_oe,
  output logic [2*NUM_COLS-1:0] level_o
);
  logic [4:0]       ctl_s;
  logic [BUS_W-1:0] pix_s;
  logic             sh_s, ln_s, fr_s, sw_s, sel_s;
  logic             sh_p, ln_p, shift_fall, line_fall;
  logic             wr_stb, done_n;
  logic [SLOT_W-1:0] wr_slot;
  logic [NUM_COLS-1:0] row;

  lcd_in_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk, .rst_n,
    .async_i({shclk_i, line_i, frame_i, show_i, dir_i ? chain_a_i : chain_b_i}),
    .sync_o (ctl_s));

  lcd_in_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_pix_sync (
    .clk, .rst_n, .async_i(pix_i), .sync_o(pix_s));

  assign {sh_s, ln_s, fr_s, sw_s, sel_s} = ctl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_p <= 1'b0;
      ln_p <= 1'b0;
    end else begin
      sh_p <= sh_s;
      ln_p <= ln_s;
    end
  end

  assign shift_fall = sh_p & ~sh_s;
  assign line_fall  = ln_p & ~ln_s;

  lcd_chain_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk, .rst_n, .shift_fall, .line_fall, .sel_n(sel_s),
    .wr_stb, .wr_slot, .done_n);

  lcd_row_reg #(.BUS_W(BUS_W), .NUM_SLOTS(NUM_SLOTS)) u_row (
    .clk, .rst_n, .dir(dir_i), .wr_stb, .wr_slot, .bus(pix_s), .row);

  lcd_out_stage #(.COLS(NUM_COLS)) u_out (
    .clk, .rst_n, .line_fall, .row, .frame(fr_s), .show(sw_s), .level_o);

  assign chain_a_oe = ~dir_i;
  assign chain_b_oe = dir_i;
  assign chain_a_o  = dir_i ? 1'b1 : done_n;
  assign chain_b_o  = dir_i ? done_n : 1'b1;
endmodule

// File: tb/lcd_col_drv_tb.sv
module lcd_col_drv_tb;
  localparam int NC = 240;
  localparam int NB = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir = 1'b0, shclk = 1'b1, line = 1'b0, frame = 1'b0, show = 1'b1;
  logic [7:0] pix = '0;
  logic a0_i, b0_i, a1_i, b1_i;
  logic a0_o, a0_oe, b0_o, b0_oe, a1_o, a1_oe, b1_o, b1_oe;
  logic [2*NC-1:0] lv0, lv1;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] sent [60];
  logic [7:0] prev_sent [60];

  always #4 clk = ~clk;

  assign a0_i = dir ? 1'b0 : 1'b1;
  assign b0_i = dir ? 1'b1 : 1'b0;
  assign a1_i = dir ? b0_o : 1'b1;
  assign b1_i = dir ? 1'b1 : a0_o;

  lcd_col_drv u_dut (.clk, .rst_n, .dir_i(dir), .shclk_i(shclk), .pix_i(pix),
    .line_i(line), .frame_i(frame), .show_i(show),
    .chain_a_i(a0_i), .chain_a_o(a0_o), .chain_a_oe(a0_oe),
    .chain_b_i(b0_i), .chain_b_o(b0_o), .chain_b_oe(b0_oe), .level_o(lv0));

  lcd_col_drv u_dut_nxt (.clk, .rst_n, .dir_i(dir), .shclk_i(shclk), .pix_i(pix),
    .line_i(line), .frame_i(frame), .show_i(show),
    .chain_a_i(a1_i), .chain_a_o(a1_o), .chain_a_oe(a1_oe),
    .chain_b_i(b1_i), .chain_b_o(b1_o), .chain_b_oe(b1_oe), .level_o(lv1));

  function automatic logic [1:0] lvl(input logic p, input logic f, input logic s);
    if (!s) return 2'b11;
    if (p && f) return 2'b00;
    if (p) return 2'b11;
    if (f) return 2'b01;
    return 2'b10;
  endfunction

  function automatic int col_of(input logic d, input int k, input int b);
    return d ? 8*k + 7 - b : 232 - 8*k + b;
  endfunction

  function automatic logic [1:0] dut_col(input int d, input int i);
    return d == 0 ? lv0[2*i +: 2] : lv1[2*i +: 2];
  endfunction

  function automatic logic dut_done(input int d);
    if (d == 0) return dir ? b0_o : a0_o;
    return dir ? b1_o : a1_o;
  endfunction

  // ---------- per-clock behavioural model ----------
  bit sh1[2], sh2[2], shp[2], ln1[2], ln2[2], lnp[2];
  bit fr1[2], fr2[2], sw1[2], sw2[2], en1[2], en2[2];
  logic [7:0] px1[2], px2[2];
  int m_cnt[2];
  bit m_done[2];
  bit m_row[2][NC], m_lat[2][NC];
  logic [1:0] m_lvl[2][NC];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        sh1[d]=0; sh2[d]=0; shp[d]=0; ln1[d]=0; ln2[d]=0; lnp[d]=0;
        fr1[d]=0; fr2[d]=0; sw1[d]=0; sw2[d]=0; en1[d]=0; en2[d]=0;
        px1[d]='0; px2[d]='0; m_cnt[d]=0; m_done[d]=1;
        for (int i = 0; i < NC; i++) begin
          m_row[d][i]=0; m_lat[d][i]=0; m_lvl[d][i]=2'b11;
        end
      end
    end else begin
      bit en_raw[2];
      en_raw[0] = 1'b0;
      en_raw[1] = m_done[0];
      for (int d = 0; d < 2; d++) begin
        for (int i = 0; i < NC; i++) m_lvl[d][i] = lvl(m_lat[d][i], fr2[d], sw2[d]);
        if (lnp[d] && !ln2[d]) begin
          for (int i = 0; i < NC; i++) m_lat[d][i] = m_row[d][i];
          m_cnt[d] = 0; m_done[d] = 1;
        end else if (shp[d] && !sh2[d] && !en2[d] && m_cnt[d] < NB) begin
          for (int b = 0; b < 8; b++) m_row[d][col_of(dir, m_cnt[d], b)] = px2[d][b];
          if (m_cnt[d] == NB-1) m_done[d] = 0;
          m_cnt[d]++;
        end
        shp[d]=sh2[d]; sh2[d]=sh1[d]; sh1[d]=shclk;
        lnp[d]=ln2[d]; ln2[d]=ln1[d]; ln1[d]=line;
        fr2[d]=fr1[d]; fr1[d]=frame; sw2[d]=sw1[d]; sw1[d]=show;
        en2[d]=en1[d]; en1[d]=en_raw[d]; px2[d]=px1[d]; px1[d]=pix;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int d = 0; d < 2; d++) begin
        int bad;
        bad = -1;
        for (int i = 0; i < NC; i++)
          if (bad < 0 && dut_col(d, i) !== m_lvl[d][i]) bad = i;
        checks++;
        if (bad >= 0) begin
          errors++;
          $display("FAIL R10 model dev%0d col%0d actual %b expected %b",
                   d, bad, dut_col(d, bad), m_lvl[d][bad]);
        end
        checks++;
        if (dut_done(d) !== m_done[d]) begin
          errors++;
          $display("FAIL R2 model dev%0d chain out actual %b expected %b",
                   d, dut_done(d), m_done[d]);
        end
      end
    end
  end

  // ---------- directed checks ----------
  task automatic check_row(input int d, input bit use_prev, input string tag);
    int bad;
    logic [1:0] e, eb;
    bad = -1;
    eb = 2'b00;
    for (int i = 0; i < NC; i++) begin
      int k, b;
      logic [7:0] byt;
      k = dir ? i/8 : 29 - i/8;
      b = dir ? 7 - i%8 : i%8;
      byt = use_prev ? prev_sent[d*NB + k] : sent[d*NB + k];
      e = lvl(byt[b], frame, show);
      if (bad < 0 && dut_col(d, i) !== e) begin bad = i; eb = e; end
    end
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s dev%0d col%0d actual %b expected %b", tag, d, bad,
               dut_col(d, bad), eb);
    end
  endtask

  task automatic check_const(input int d, input logic [1:0] e, input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < NC; i++) if (bad < 0 && dut_col(d, i) !== e) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s dev%0d col%0d actual %b expected %b", tag, d, bad,
               dut_col(d, bad), e);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    @(negedge clk);
    pix = v; shclk = 1'b0;
    wait_clk(4);
    shclk = 1'b1;
    wait_clk(4);
  endtask

  task automatic pulse_line();
    @(negedge clk); line = 1'b1;
    wait_clk(4); line = 1'b0;
    wait_clk(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int dv = 0; dv < 2; dv++) begin
      string rmap;
      rmap = dv ? "R5" : "R4";
      @(negedge clk);
      rst_n = 1'b0; dir = dv[0]; frame = 1'b0; show = 1'b1; line = 1'b0; shclk = 1'b1;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(6);
      // R9: reset state
      check_const(0, 2'b10, "R9 reset levels");
      check_const(1, 2'b10, "R9 reset levels");
      check_bit(dut_done(0), 1'b1, "R9 dev0 chain out after reset");
      check_bit(a0_oe, ~dir, {rmap, " pin A oe"});
      check_bit(b0_oe, dir, {rmap, " pin B oe"});
      check_bit(dir ? a0_o : b0_o, 1'b1, {rmap, " unused out pin"});

      for (int j = 0; j < 60; j++) sent[j] = 8'(j*37 + dv*91 + 5);
      for (int j = 0; j < 30; j++) send_byte(sent[j]);
      wait_clk(4);
      check_bit(dut_done(0), 1'b0, "R2 dev0 chain out after 30 bytes");
      check_bit(dut_done(1), 1'b1, "R2 dev1 chain out idle");
      for (int j = 30; j < 60; j++) send_byte(sent[j]);
      for (int j = 0; j < 5; j++) send_byte(8'hFF);   // R3 surplus bytes
      wait_clk(4);
      check_bit(dut_done(1), 1'b0, "R2 dev1 chain out after 30 bytes");
      check_const(0, 2'b10, "R6 no change before latch");
      check_const(1, 2'b10, "R6 no change before latch");

      @(negedge clk); frame = 1'b1;
      pulse_line();
      check_row(0, 0, {rmap, " R1 R3 R7 dev0 row frame1"});
      check_row(1, 0, {rmap, " R1 R3 R7 dev1 row frame1"});
      check_bit(dut_done(0), 1'b1, "R2 dev0 chain out after latch");
      check_bit(dut_done(1), 1'b1, "R2 dev1 chain out after latch");

      @(negedge clk); frame = 1'b0;
      wait_clk(6);
      check_row(0, 0, "R7 dev0 row frame0");
      check_row(1, 0, "R7 dev1 row frame0");

      @(negedge clk); show = 1'b0;
      wait_clk(6);
      check_const(0, 2'b11, "R8 blank dev0");
      check_const(1, 2'b11, "R8 blank dev1");
      @(negedge clk); show = 1'b1;
      wait_clk(6);

      for (int j = 0; j < 60; j++) prev_sent[j] = sent[j];
      for (int j = 0; j < 60; j++) sent[j] = 8'(j*113 + dv*29 + 200);
      for (int j = 0; j < 60; j++) send_byte(sent[j]);
      wait_clk(4);
      check_row(0, 1, "R6 dev0 holds old row");
      check_row(1, 1, "R6 dev1 holds old row");
      pulse_line();
      check_row(0, 0, "R1 dev0 second row");
      check_row(1, 0, "R1 dev1 second row");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule